// File: doc/BRIEF.md
# Serial Control and Status Slave

This block is the two-wire serial slave of a supply controller. It watches clock and data samples from the bus pads, finds start and stop conditions, matches its seven-bit address and drives an open-drain enable on the data line to acknowledge or to return data. A write carries exactly one data byte. The two top bits of that byte select one of two six-bit control fields, and the low six bits are the new value. A read returns the two status bytes from the surrounding logic, always starting with the first and then alternating for as long as the master acknowledges.

The slave stays silent until the internal logic supply is reported good. Three single-cycle strobes mark an acknowledged address, an accepted data byte and the rising clock edge that follows each status byte. The status logic uses the last strobe as its update point.

Top module: `i2cs_ctrl_status`

## Requirements
- R1: After reset both control fields read 0 and `sda_oe` is 0, so the data line is released.
- R2: The address byte is received MSB first. Its top seven bits must equal `00010` followed by `addr_strap[1:0]`. Its last bit is the direction, where 1 means read. On a match the slave pulls the data line low for the ninth clock.
- R3: On an address mismatch `sda_oe` stays 0 for the rest of the transaction.
- R4: A write data byte is acknowledged. If bits 7:6 are `00`, bits 5:0 go to `ctrl_a_o`. If bits 7:6 are `10`, bits 5:0 go to `ctrl_b_o`. The control fields change only on such a write.
- R5: A write data byte with bits 7:6 equal to `01` or `11` is acknowledged, and both control fields keep their values.
- R6: Only one data byte is accepted per write. Any further byte in the same transaction gets no acknowledge and changes no control field.
- R7: A read returns `stat1_i` first, MSB first. Each master acknowledge (data low on the ninth clock) makes the next byte the other status register, giving the order 1, 2, 1, 2 and so on.
- R8: After a master NAK the data line stays released until the next start. The next read begins again with `stat1_i`.
- R9: A start or stop condition seen in any state restarts the sequence. An interrupted write changes no control field.
- R10: While `supply_ok` is 0 the slave does not acknowledge, does not write and raises no strobe.
- R11: `addr_ack_pulse` is high for one cycle per matched address. `write_done_pulse` is high for one cycle per acknowledged data byte. `status_upd_pulse` is high for one cycle on the ninth rising clock after each read byte. No two strobes are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Internal logic supply good; 0 keeps the slave silent |
| addr_strap | input | 2 | Strap value for the two low address bits |
| scl_i | input | 1 | Bus clock from the pad |
| sda_i | input | 1 | Bus data from the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| stat1_i | input | 8 | First status byte |
| stat2_i | input | 8 | Second status byte |
| ctrl_a_o | output | 6 | Control field at index 00 |
| ctrl_b_o | output | 6 | Control field at index 10 |
| addr_ack_pulse | output | 1 | Address matched and acknowledged |
| write_done_pulse | output | 1 | Data byte accepted |
| status_upd_pulse | output | 1 | Ninth-clock update point of a read byte |

## Verification
A pad edge reaches the protocol state machine after two synchroniser flops and one edge flop. The state machine's outputs, `sda_oe` and the strobes, therefore change at most four system clocks after the pad edge. The control fields follow one clock after `write_done_pulse`. The bench holds each bus phase for five system clocks and samples the data line just before the next bus edge, so every acknowledge and data bit is read after it has settled. Control fields are compared only after the stop condition, and strobe counts are compared once the transaction has ended.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W   = 8;
    localparam int CTRL_W   = 6;
    localparam int IDX_W    = BYTE_W - CTRL_W;
    localparam int NUM_CTRL = 2;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    // Register index that each control field answers to
    localparam logic [IDX_W-1:0] CTRL_IDX [NUM_CTRL] = '{2'b00, 2'b10};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_PARK
    } slv_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              stb;
        logic [IDX_W-1:0]  idx;
        logic [CTRL_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [6:0] rx,
                                      input logic [4:0] prefix,
                                      input logic [1:0] strap);
        return rx == {prefix, strap};
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.scl_rise = scl & ~scl_q;
        ev.scl_fall = ~scl & scl_q;
        ev.start    = scl & scl_q & sda_q & ~sda;
        ev.stop     = scl & scl_q & ~sda_q & sda;
        ev.sda      = sda;
    end
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    output logic [CTRL_W-1:0] ctrl [NUM_CTRL]
);
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                ctrl[g] <= '0;
            else if (wr.stb && wr.idx == CTRL_IDX[g])
                ctrl[g] <= wr.data;
        end
    end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b00010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic [1:0]        addr_strap,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] stat1,
    input  logic [BYTE_W-1:0] stat2,
    output logic              sda_oe,
    output wr_req_t           wr,
    output logic              addr_ack_pulse,
    output logic              status_upd_pulse
);
    slv_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              sel;
    logic              mack;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            state            <= ST_IDLE;
            cnt              <= '0;
            sh               <= '0;
            tx               <= '0;
            rw               <= 1'b0;
            sel              <= 1'b0;
            mack             <= 1'b0;
            sda_oe           <= 1'b0;
            wr               <= '0;
            addr_ack_pulse   <= 1'b0;
            status_upd_pulse <= 1'b0;
        end else begin
            wr.stb           <= 1'b0;
            addr_ack_pulse   <= 1'b0;
            status_upd_pulse <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + CNT_W'(1);
                        end else if (ev.scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            if (state == ST_WDATA) begin
                                sda_oe  <= 1'b1;
                                wr.stb  <= 1'b1;
                                wr.idx  <= sh[BYTE_W-1 -: IDX_W];
                                wr.data <= sh[CTRL_W-1:0];
                                state   <= ST_WACK;
                            end else if (addr_hit(sh[7:1], ADDR_PREFIX, addr_strap)) begin
                                sda_oe         <= 1'b1;
                                rw             <= sh[0];
                                addr_ack_pulse <= 1'b1;
                                state          <= ST_AACK;
                            end else begin
                                state <= ST_PARK;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                sel    <= 1'b0;
                                tx     <= stat1;
                                sda_oe <= ~stat1[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_PARK;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + CNT_W'(1);
                        end else if (ev.scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[3'(CNT_W'(BYTE_W - 1) - cnt)];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            mack             <= ~ev.sda;
                            status_upd_pulse <= 1'b1;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                sel    <= ~sel;
                                tx     <= sel ? stat1 : stat2;
                                sda_oe <= sel ? ~stat1[BYTE_W-1] : ~stat2[BYTE_W-1];
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                state  <= ST_PARK;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_ctrl_status.sv
module i2cs_ctrl_status
    import i2cs_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b00010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic [1:0]        addr_strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] stat1_i,
    input  logic [BYTE_W-1:0] stat2_i,
    output logic [CTRL_W-1:0] ctrl_a_o,
    output logic [CTRL_W-1:0] ctrl_b_o,
    output logic              addr_ack_pulse,
    output logic              write_done_pulse,
    output logic              status_upd_pulse
);
    logic [1:0]        pads_s;
    bus_ev_t           ev;
    wr_req_t           wr;
    logic [CTRL_W-1:0] ctrl [NUM_CTRL];

    i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (pads_s)
    );

    i2cs_cond u_cond (
        .clk (clk),
        .rst (rst),
        .scl (pads_s[1]),
        .sda (pads_s[0]),
        .ev  (ev)
    );

    i2cs_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
        .clk              (clk),
        .rst              (rst),
        .supply_ok        (supply_ok),
        .addr_strap       (addr_strap),
        .ev               (ev),
        .stat1            (stat1_i),
        .stat2            (stat2_i),
        .sda_oe           (sda_oe),
        .wr               (wr),
        .addr_ack_pulse   (addr_ack_pulse),
        .status_upd_pulse (status_upd_pulse)
    );

    i2cs_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .ctrl (ctrl)
    );

    assign ctrl_a_o         = ctrl[0];
    assign ctrl_b_o         = ctrl[1];
    assign write_done_pulse = wr.stb;
endmodule

// File: rtl/i2cs_ctrl_status_chk.sv
module i2cs_ctrl_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       sda_oe,
    input logic [5:0] ctrl_a_o,
    input logic [5:0] ctrl_b_o,
    input logic       addr_ack_pulse,
    input logic       write_done_pulse,
    input logic       status_upd_pulse
);
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_a_o == 6'd0 && ctrl_b_o == 6'd0 && !sda_oe));

    a_r2_ack_drives_line: assert property (@(posedge clk) disable iff (rst)
        addr_ack_pulse |-> sda_oe);

    a_r4_fields_move_on_write: assert property (@(posedge clk) disable iff (rst)
        !write_done_pulse |=> ($stable(ctrl_a_o) && $stable(ctrl_b_o)));

    a_r10_silent_without_supply: assert property (@(posedge clk) disable iff (rst)
        $past(!supply_ok) |-> (!sda_oe && !addr_ack_pulse && !write_done_pulse && !status_upd_pulse));

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_ack_pulse, write_done_pulse, status_upd_pulse}));

    a_r11_ack_strobe_single: assert property (@(posedge clk) disable iff (rst)
        addr_ack_pulse |=> !addr_ack_pulse);
endmodule

bind i2cs_ctrl_status i2cs_ctrl_status_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .supply_ok        (supply_ok),
    .sda_oe           (sda_oe),
    .ctrl_a_o         (ctrl_a_o),
    .ctrl_b_o         (ctrl_b_o),
    .addr_ack_pulse   (addr_ack_pulse),
    .write_done_pulse (write_done_pulse),
    .status_upd_pulse (status_upd_pulse)
);

// File: tb/i2cs_ctrl_status_tb.sv
module i2cs_ctrl_status_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       supply_ok = 1'b1;
    logic [1:0] strap = 2'd0;
    logic [7:0] st1 = 8'h00;
    logic [7:0] st2 = 8'h00;

    logic       sda_oe;
    logic [5:0] ca, cb;
    logic       aap, wdp, sup;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int n_aa = 0, n_wd = 0, n_su = 0, n_oe = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2cs_ctrl_status u_dut (
        .clk              (clk),
        .rst              (rst),
        .supply_ok        (supply_ok),
        .addr_strap       (strap),
        .scl_i            (scl_m),
        .sda_i            (sda_line),
        .sda_oe           (sda_oe),
        .stat1_i          (st1),
        .stat2_i          (st2),
        .ctrl_a_o         (ca),
        .ctrl_b_o         (cb),
        .addr_ack_pulse   (aap),
        .write_done_pulse (wdp),
        .status_upd_pulse (sup)
    );

    always @(posedge clk) begin
        if (aap)    n_aa <= n_aa + 1;
        if (wdp)    n_wd <= n_wd + 1;
        if (sup)    n_su <= n_su + 1;
        if (sda_oe) n_oe <= n_oe + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit ack);
        logic l;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        read_bit(l);
        ack = !l;
    endtask

    task automatic rd_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) read_bit(v[i]);
    endtask

    // One complete single-byte write transaction
    task automatic write_txn(input logic [1:0] lo, input logic [7:0] d,
                             output bit a_ack, output bit d_ack);
        bus_start();
        wr_byte({5'b00010, lo, 1'b0}, a_ack);
        wr_byte(d, d_ack);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a_ack, d_ack;
        logic [7:0] rb;
        logic [5:0] exp_a, exp_b;
        int aa0, wd0, su0, oe0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(sda_oe == 1'b0, "R1 line released", sda_oe, 0);
        check(ca == 6'd0, "R1 ctrl_a", ca, 0);
        check(cb == 6'd0, "R1 ctrl_b", cb, 0);
        check(!aap && !wdp && !sup, "R11 strobes idle", {aap, wdp, sup}, 0);
        exp_a = 6'd0;
        exp_b = 6'd0;

        // R2 R3 R4: every strap against every low address pair
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                logic [5:0] d;
                strap = 2'(s);
                d = 6'(s * 13 + a * 5 + 1);
                wq();
                oe0 = n_oe; aa0 = n_aa;
                write_txn(2'(a), {2'b00, d}, a_ack, d_ack);
                if (a == s) begin
                    exp_a = d;
                    check(a_ack, "R2 address ack", a_ack, 1);
                    check(d_ack, "R4 data ack", d_ack, 1);
                    check(n_aa - aa0 == 1, "R11 one address strobe", n_aa - aa0, 1);
                end else begin
                    check(!a_ack, "R2 foreign address not acked", a_ack, 0);
                    check(n_oe == oe0, "R3 line untouched", n_oe - oe0, 0);
                end
                check(ca == exp_a, "R4 ctrl_a after sweep write", ca, exp_a);
            end
        end

        strap = 2'd2;
        wq();
        // R4: index 10
        wd0 = n_wd;
        write_txn(2'd2, {2'b10, 6'h2A}, a_ack, d_ack);
        exp_b = 6'h2A;
        check(d_ack, "R4 index 10 acked", d_ack, 1);
        check(cb == exp_b, "R4 ctrl_b", cb, exp_b);
        check(ca == exp_a, "R4 ctrl_a kept", ca, exp_a);
        check(n_wd - wd0 == 1, "R11 one write strobe", n_wd - wd0, 1);

        // R5: unused indices 01 and 11
        write_txn(2'd2, {2'b01, 6'h15}, a_ack, d_ack);
        check(d_ack, "R5 index 01 acked", d_ack, 1);
        write_txn(2'd2, {2'b11, 6'h33}, a_ack, d_ack);
        check(d_ack, "R5 index 11 acked", d_ack, 1);
        check(ca == exp_a && cb == exp_b, "R5 fields kept", {ca, cb}, {exp_a, exp_b});

        // R6: second data byte in one write
        bus_start();
        wr_byte({5'b00010, 2'd2, 1'b0}, a_ack);
        wr_byte({2'b00, 6'h07}, d_ack);
        exp_a = 6'h07;
        wr_byte({2'b00, 6'h38}, d_ack);
        check(!d_ack, "R6 second byte not acked", d_ack, 0);
        bus_stop();
        check(ca == exp_a, "R6 first byte kept", ca, exp_a);

        // R7 R8 R11: alternating read
        st1 = 8'hA5; st2 = 8'h3C;
        su0 = n_su;
        bus_start();
        wr_byte({5'b00010, 2'd2, 1'b1}, a_ack);
        check(a_ack, "R2 read address ack", a_ack, 1);
        rd_byte(rb); send_bit(1'b0);
        check(rb == 8'hA5, "R7 first byte status1", rb, 8'hA5);
        rd_byte(rb); send_bit(1'b0);
        check(rb == 8'h3C, "R7 second byte status2", rb, 8'h3C);
        rd_byte(rb); send_bit(1'b1);
        check(rb == 8'hA5, "R7 third byte status1", rb, 8'hA5);
        check(n_su - su0 == 3, "R11 update strobes", n_su - su0, 3);
        oe0 = n_oe;
        rd_byte(rb);
        check(rb == 8'hFF && n_oe == oe0, "R8 released after NAK", rb, 8'hFF);
        bus_stop();

        st1 = 8'h5A; st2 = 8'hC3;
        bus_start();
        wr_byte({5'b00010, 2'd2, 1'b1}, a_ack);
        rd_byte(rb); send_bit(1'b1);
        check(rb == 8'h5A, "R8 new read restarts at status1", rb, 8'h5A);
        bus_stop();

        // R9: start in the middle of an address, stop in the middle of data
        bus_start();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        wr_byte({5'b00010, 2'd2, 1'b0}, a_ack);
        check(a_ack, "R9 restart then address ack", a_ack, 1);
        wr_byte({2'b10, 6'h11}, d_ack);
        bus_stop();
        exp_b = 6'h11;
        check(cb == exp_b, "R9 write after restart", cb, exp_b);
        bus_start();
        wr_byte({5'b00010, 2'd2, 1'b0}, a_ack);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        check(ca == exp_a && cb == exp_b, "R9 cut write ignored", {ca, cb}, {exp_a, exp_b});

        // R10: supply not good
        supply_ok = 1'b0;
        aa0 = n_aa; wd0 = n_wd;
        write_txn(2'd2, {2'b00, 6'h3F}, a_ack, d_ack);
        check(!a_ack, "R10 no ack without supply", a_ack, 0);
        check(ca == exp_a, "R10 no write without supply", ca, exp_a);
        check(n_aa == aa0 && n_wd == wd0, "R10 no strobes", n_aa - aa0, 0);
        supply_ok = 1'b1;
        wq();
        write_txn(2'd2, {2'b00, 6'h2C}, a_ack, d_ack);
        exp_a = 6'h2C;
        check(a_ack && ca == exp_a, "R10 works after supply good", ca, exp_a);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule